// File: doc/BRIEF.md
# Programmable Rank-Order and k-Winners Selector

This block looks at a set of parallel input words and returns a bit mask that marks the inputs standing at a chosen position in their sorted order. A one-bit mode input picks between two readings of a small select code. In exact-rank mode the mask marks the single input whose position equals the code: 0 is the smallest, NUM_IN-1 the largest. In k-winners mode it marks every input whose position is at least the code, which is the top NUM_IN-code inputs.

Internally every unordered pair of inputs is compared once. The opposite ordering of each pair is the complement of that result. Each input then gets a score, which is the number of other inputs it beats. Equal inputs are ordered by index, so the scores always form a permutation of 0..NUM_IN-1, and that score is matched against the select code.

A computation begins with a one-cycle start strobe, which captures the inputs, the mode and the code. It then runs through three phases: capture, pairwise compare and score evaluation. The mask and a one-cycle valid pulse are registered one cycle after evaluation.

Top module: `rank_kwta_select`

## Requirements
- R1: While reset is applied and after it is released, `win_mask` is all zeros and `res_valid` is 0.
- R2: In exact-rank mode (`kwta_mode` = 0), with a code below NUM_IN, exactly one mask bit is set. Bit i is set when the number of inputs that input i beats equals the code, so code 0 marks the smallest input and code NUM_IN-1 marks the largest.
- R3: In k-winners mode (`kwta_mode` = 1), bit i is set when the score of input i is at least the code, so exactly max(NUM_IN-code, 0) bits are set. Code 0 sets every bit.
- R4: Input i beats input j when its word is greater (unsigned), or when the words are equal and i < j.
- R5: In exact-rank mode, a code at or above NUM_IN gives an all-zero mask.
- R6: A start accepted at clock edge E0 produces the new mask and `res_valid` = 1 after edge E0+3. `res_valid` stays high for exactly one cycle.
- R7: A start seen while a computation is in progress is ignored. The result uses only the inputs, mode and code captured at the accepted start.
- R8: Between results, `win_mask` keeps its last value regardless of changes on the inputs.
- R9: Mask bit i corresponds to input word i, which occupies bits [i*DATA_W +: DATA_W] of `in_flat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_flat | input | NUM_IN*DATA_W | Packed input words, word i at bits [i*DATA_W +: DATA_W] |
| kwta_mode | input | 1 | 0 selects exact rank, 1 selects k-winners |
| sel_code | input | SEL_W | Rank or threshold code |
| start | input | 1 | Begins a computation when the block is idle |
| win_mask | output | NUM_IN | Registered result mask, one bit per input |
| res_valid | output | 1 | One-cycle pulse when a new mask is presented |

## Verification
The checker tracks accepted starts on its own and checks the following on every cycle:
- the three-cycle latency and the one-cycle width of the valid pulse;
- that an exact-rank result is one-hot for an in-range code and empty for an out-of-range code;
- that a k-winners result has exactly NUM_IN-code bits set;
- that the mask never moves without a valid pulse.

Which input is marked can only be shown by the directed scenarios, since it depends on the data. These scenarios cover tie ordering by index, rejection of a start while busy, and capture of the inputs at the accepted start.

// File: rtl/rko_pkg.sv
// Shared types for the rank-order selector.
// Assumes: four sequential phases, encoded in two bits.
package rko_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMP  = 2'd1,
        PH_EVAL = 2'd2,
        PH_OUT  = 2'd3
    } phase_t;
endpackage

// File: rtl/rko_pair_array.sv
// Pairwise comparison array. It registers one comparator result per
// unordered pair (i<j). The reverse ordering is derived as the complement.
// Assumes: unsigned words; on equal words the lower index wins.
// Output bit beat_flat[i*NUM_IN+j] is 1 when input i beats input j.
module rko_pair_array #(
    parameter int NUM_IN = 7,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NUM_IN*DATA_W-1:0] data_flat,
    output logic [NUM_IN*NUM_IN-1:0] beat_flat
);
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_row
        for (genvar gj = 0; gj < NUM_IN; gj++) begin : g_col
            if (gi < gj) begin : g_upper
                logic win_q;
                // Capture one shared comparator result for pair (gi,gj).
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        win_q <= 1'b0;
                    else if (load)
                        win_q <= (data_flat[gi*DATA_W +: DATA_W] >= data_flat[gj*DATA_W +: DATA_W]);
                end
                assign beat_flat[gi*NUM_IN+gj] = win_q;
            end else if (gi > gj) begin : g_lower
                assign beat_flat[gi*NUM_IN+gj] = ~beat_flat[gj*NUM_IN+gi];
            end else begin : g_diag
                assign beat_flat[gi*NUM_IN+gj] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rko_score.sv
// Win counter. For each input it registers the number of pairwise wins.
// Assumes: the diagonal of the win matrix is zero.
module rko_score #(
    parameter int NUM_IN = 7,
    parameter int CNT_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NUM_IN*NUM_IN-1:0] beat_flat,
    output logic [NUM_IN*CNT_W-1:0]  score_flat
);
    logic [NUM_IN*CNT_W-1:0] sum_d;

    // Population count of each row of the win matrix.
    always_comb begin
        sum_d = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            for (int j = 0; j < NUM_IN; j++) begin
                sum_d[i*CNT_W +: CNT_W] = sum_d[i*CNT_W +: CNT_W] + CNT_W'(beat_flat[i*NUM_IN+j]);
            end
        end
    end

    // Register the scores for the evaluate phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            score_flat <= '0;
        else if (load)
            score_flat <= sum_d;
    end
endmodule

// File: rtl/rko_decide.sv
// Score-to-code matcher. Rank mode tests equality; k-winners mode tests
// score >= code. Purely combinational.
// Assumes: both operands are unsigned and zero-extended to a common width.
module rko_decide #(
    parameter int NUM_IN = 7,
    parameter int CNT_W  = 3,
    parameter int SEL_W  = 3
) (
    input  logic [NUM_IN*CNT_W-1:0] score_flat,
    input  logic                    kwta,
    input  logic [SEL_W-1:0]        code,
    output logic [NUM_IN-1:0]       match
);
    localparam int CW = (CNT_W > SEL_W) ? CNT_W : SEL_W;

    logic [CW-1:0] code_x;
    assign code_x = CW'(code);

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_cmp
        logic [CW-1:0] sc_x;
        assign sc_x = CW'(score_flat[gi*CNT_W +: CNT_W]);
        // Compare one input's score with the select code.
        always_comb begin
            if (kwta)
                match[gi] = (sc_x >= code_x);
            else
                match[gi] = (sc_x == code_x);
        end
    end
endmodule

// File: rtl/rank_kwta_select.sv
// Top of the rank-order / k-winners selector.
// Sequence: start (idle) captures inputs, then compare, evaluate, output.
// Starts arriving while busy are dropped.
// Assumes: NUM_IN >= 2 and NUM_IN <= 2**SEL_W.
module rank_kwta_select #(
    parameter int NUM_IN = 7,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN*DATA_W-1:0] in_flat,
    input  logic                     kwta_mode,
    input  logic [SEL_W-1:0]         sel_code,
    input  logic                     start,
    output logic [NUM_IN-1:0]        win_mask,
    output logic                     res_valid
);
    import rko_pkg::*;

    localparam int CNT_W = $clog2(NUM_IN);

    phase_t                    phase_q;
    logic [NUM_IN*DATA_W-1:0]  smp_data_q;
    logic                      smp_mode_q;
    logic [SEL_W-1:0]          smp_code_q;
    logic [NUM_IN*NUM_IN-1:0]  beat_flat;
    logic [NUM_IN*CNT_W-1:0]   score_flat;
    logic [NUM_IN-1:0]         match;
    logic                      accept;

    assign accept = start && (phase_q == PH_IDLE);

    // Phase sequencer: idle -> compare -> evaluate -> output -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (accept) phase_q <= PH_CMP;
                PH_CMP:  phase_q <= PH_EVAL;
                PH_EVAL: phase_q <= PH_OUT;
                PH_OUT:  phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Sample phase: hold inputs, mode and code for the whole computation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_data_q <= '0;
            smp_mode_q <= 1'b0;
            smp_code_q <= '0;
        end else if (accept) begin
            smp_data_q <= in_flat;
            smp_mode_q <= kwta_mode;
            smp_code_q <= sel_code;
        end
    end

    rko_pair_array #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) i_pairs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (phase_q == PH_CMP),
        .data_flat (smp_data_q),
        .beat_flat (beat_flat)
    );

    rko_score #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) i_score (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (phase_q == PH_EVAL),
        .beat_flat  (beat_flat),
        .score_flat (score_flat)
    );

    rko_decide #(.NUM_IN(NUM_IN), .CNT_W(CNT_W), .SEL_W(SEL_W)) i_decide (
        .score_flat (score_flat),
        .kwta       (smp_mode_q),
        .code       (smp_code_q),
        .match      (match)
    );

    // Output register: new mask and a one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_mask  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= (phase_q == PH_OUT);
            if (phase_q == PH_OUT)
                win_mask <= match;
        end
    end
endmodule

// File: rtl/rank_kwta_select_chk.sv
// Port-level checker for rank_kwta_select.
// It tracks accepted starts with its own countdown and captures mode and code.
module rank_kwta_select_chk #(
    parameter int NUM_IN = 7,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kwta_mode,
    input logic [SEL_W-1:0]  sel_code,
    input logic              start,
    input logic [NUM_IN-1:0] win_mask,
    input logic              res_valid
);
    logic [1:0]       left_q;
    logic             vexp_q;
    logic             cmode_q;
    logic [SEL_W-1:0] ccode_q;
    int               want_ones;

    // Independent countdown of an accepted computation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= 2'd0;
            vexp_q  <= 1'b0;
            cmode_q <= 1'b0;
            ccode_q <= '0;
        end else begin
            vexp_q <= (left_q == 2'd1);
            if (start && left_q == 2'd0) begin
                left_q  <= 2'd3;
                cmode_q <= kwta_mode;
                ccode_q <= sel_code;
            end else if (left_q != 2'd0) begin
                left_q <= left_q - 2'd1;
            end
        end
    end

    // Expected population of a k-winners mask.
    always_comb begin
        if (int'(ccode_q) >= NUM_IN)
            want_ones = 0;
        else
            want_ones = NUM_IN - int'(ccode_q);
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == vexp_q);                                                   // R6
    AST_RANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cmode_q && int'(ccode_q) < NUM_IN) |-> $onehot(win_mask)); // R2
    AST_RANK_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cmode_q && int'(ccode_q) >= NUM_IN) |-> (win_mask == '0)); // R5
    AST_KWIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cmode_q) |-> ($countones(win_mask) == want_ones));       // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(win_mask));                                      // R8
endmodule

bind rank_kwta_select rank_kwta_select_chk #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .kwta_mode (kwta_mode),
    .sel_code  (sel_code),
    .start     (start),
    .win_mask  (win_mask),
    .res_valid (res_valid)
);

// File: tb/test_rank_kwta_select.sv
module test_rank_kwta_select;
    localparam int  M      = 7;
    localparam int  DW     = 8;
    localparam int  SW     = 3;
    localparam time CLK_PER = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [M*DW-1:0] in_flat = '0;
    logic            kwta_mode = 1'b0;
    logic [SW-1:0]   sel_code = '0;
    logic            start = 1'b0;
    logic [M-1:0]    win_mask;
    logic            res_valid;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PER/2) clk = ~clk;

    rank_kwta_select #(.NUM_IN(M), .DATA_W(DW), .SEL_W(SW)) i_rank_kwta_select (
        .clk(clk), .rst_n(rst_n), .in_flat(in_flat), .kwta_mode(kwta_mode),
        .sel_code(sel_code), .start(start), .win_mask(win_mask), .res_valid(res_valid)
    );

    task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Expected mask from the requirement text (R2, R3, R4, R5, R9).
    function automatic logic [M-1:0] model(input logic [M*DW-1:0] d, input logic m, input logic [SW-1:0] c);
        logic [M-1:0] r = '0;
        for (int i = 0; i < M; i++) begin
            int sc = 0;
            for (int j = 0; j < M; j++) begin
                if (j != i) begin
                    if (d[i*DW +: DW] > d[j*DW +: DW] || (d[i*DW +: DW] == d[j*DW +: DW] && i < j))
                        sc++;
                end
            end
            r[i] = m ? (sc >= int'(c)) : (sc == int'(c));
        end
        return r;
    endfunction

    function automatic logic [M*DW-1:0] pack7(input int a0, a1, a2, a3, a4, a5, a6);
        logic [M*DW-1:0] v;
        v[0*DW +: DW] = DW'(a0); v[1*DW +: DW] = DW'(a1); v[2*DW +: DW] = DW'(a2);
        v[3*DW +: DW] = DW'(a3); v[4*DW +: DW] = DW'(a4); v[5*DW +: DW] = DW'(a5);
        v[6*DW +: DW] = DW'(a6);
        return v;
    endfunction

    // Launch a computation and return at the negedge after the result edge.
    task automatic launch(input logic [M*DW-1:0] d, input logic m, input logic [SW-1:0] c);
        @(negedge clk); in_flat = d; kwta_mode = m; sel_code = c; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 valid early", M'(res_valid), M'(0));
        @(negedge clk);
        check("R6 valid at E0+3", M'(res_valid), M'(1));
    endtask

    task automatic run_one(input string req, input logic [M*DW-1:0] d, input logic m, input logic [SW-1:0] c);
        launch(d, m, c);
        check(req, win_mask, model(d, m, c));
        @(negedge clk);
        check("R6 pulse width", M'(res_valid), M'(0));
    endtask

    task automatic t_reset;
        check("R1 mask", win_mask, '0);
        check("R1 valid", M'(res_valid), M'(0));
    endtask

    task automatic t_example;
        logic [M*DW-1:0] d = pack7(50, 60, 90, 20, 40, 70, 10);
        launch(d, 1'b0, 3'd6); check("R2 max", win_mask, 7'b0000100);
        launch(d, 1'b0, 3'd3); check("R2 median", win_mask, 7'b0000001);
        launch(d, 1'b0, 3'd0); check("R2 min", win_mask, 7'b1000000);
        launch(d, 1'b0, 3'd5); check("R9 next max", win_mask, 7'b0100000);
        launch(d, 1'b1, 3'd4); check("R3 3-winners", win_mask, 7'b0100110);
        launch(d, 1'b1, 3'd0); check("R3 all winners", win_mask, 7'b1111111);
    endtask

    task automatic t_rank_sweep;
        logic [M*DW-1:0] d = pack7(3, 200, 17, 99, 128, 0, 64);
        for (int c = 0; c < 8; c++)
            run_one(c >= M ? "R5 out of range" : "R2 rank sweep", d, 1'b0, SW'(c));
    endtask

    task automatic t_kwin_sweep;
        logic [M*DW-1:0] d = pack7(255, 1, 77, 78, 9, 140, 33);
        for (int c = 0; c < 8; c++)
            run_one("R3 k-winners sweep", d, 1'b1, SW'(c));
    endtask

    task automatic t_ties;
        logic [M*DW-1:0] d = pack7(42, 42, 42, 42, 42, 42, 42);
        launch(d, 1'b0, 3'd6); check("R4 tie max is lowest index", win_mask, 7'b0000001);
        launch(d, 1'b0, 3'd0); check("R4 tie min is highest index", win_mask, 7'b1000000);
        d = pack7(10, 30, 30, 5, 30, 1, 2);
        launch(d, 1'b0, 3'd5); check("R4 partial tie", win_mask, 7'b0000100);
        launch(d, 1'b1, 3'd4); check("R4 partial tie k", win_mask, 7'b0010110);
    endtask

    task automatic t_busy;
        logic [M*DW-1:0] d1 = pack7(9, 8, 7, 6, 5, 4, 3);
        @(negedge clk); in_flat = d1; kwta_mode = 1'b0; sel_code = 3'd6; start = 1'b1;
        @(negedge clk); in_flat = pack7(1, 2, 3, 4, 5, 6, 7); kwta_mode = 1'b1; sel_code = 3'd0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); start = 1'b0;
        check("R7 result from accepted start", win_mask, 7'b0000001);
        check("R7 valid", M'(res_valid), M'(1));
        @(negedge clk); check("R7 no second result", M'(res_valid), M'(0));
        @(negedge clk); check("R7 no second result", M'(res_valid), M'(0));
        @(negedge clk); check("R7 no second result", M'(res_valid), M'(0));
    endtask

    task automatic t_hold;
        logic [M-1:0] held = win_mask;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); in_flat = ~in_flat; kwta_mode = ~kwta_mode; sel_code = sel_code + 1'b1;
        end
        @(negedge clk);
        check("R8 mask holds", win_mask, held);
    endtask

    task automatic t_random;
        for (int n = 0; n < 24; n++) begin
            logic [M*DW-1:0] d;
            for (int i = 0; i < M; i++) begin
                rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
                d[i*DW +: DW] = (n % 3 == 0) ? DW'(rng[1:0]) : rng[DW-1:0];
            end
            run_one(n[0] ? "R3 random" : "R2 random", d, n[0], SW'(n % 8));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_rank_sweep();
        t_kwin_sweep();
        t_ties();
        t_busy();
        t_hold();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule